// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host side of a byte-wide printer port. A host reaches three registers (output data, status and control) through a simple synchronous bus. Each cycle carries at most one read or one write, selected by a three-bit offset. The attached printer is not wired up. Instead, its handshake is modelled inside the block: the status register moves through a busy/acknowledge sequence as the host polls it. Writes to control trigger the printer behaviour: an initialise, a byte transmit, or an interrupt request.

When the host raises the strobe bit in control, the byte held in the output data latch is handed out on `tx_data` with a one-clock `tx_valid` pulse. A separate input latch captures a byte from an external port whenever `in_load` is high. A data read returns that input latch when the control direction bit is set. The `irq` output is a level that follows the internal interrupt-pending flag.

Top module: `pp_regs`

## Requirements
- R1: Offset 0 selects data, offset 1 selects status and offset 2 selects control. A read presents its value on `bus_rdata` after the next rising edge, and `bus_rdata` holds until the next read.
- R2: Reads of offsets 3 to 7 return 0xFF. Writes to offsets 1 and 3 to 7 change no register.
- R3: Control stores the written byte with bits 7 and 6 forced to 1, and a control read returns the stored byte.
- R4: A control write with bit 2 (initialise) at 0 loads status with 0xD8, whatever the other bits are.
- R5: A control write with bit 2=1, bit 3 (select)=1 and bit 0 (strobe)=1 clears status bit 7 (busy). If the stored strobe bit was 0 before that write, the output data byte also appears on `tx_data`, with `tx_valid` high for exactly the cycle after the write.
- R6: A control write with bit 2=1, bit 3=1 and bit 0=0 sets interrupt-pending if the control value stored before the write has bit 4 (interrupt enable) set.
- R7: A status read returns the status from before the read. The status then advances if busy (bit 7) and the stored strobe bit are both 0: a set acknowledge bit (bit 6) is cleared, and a clear one sets both bit 6 and bit 7.
- R8: A status read clears interrupt-pending, so `irq` is low after that edge.
- R9: `irq` equals interrupt-pending and changes only on control writes and status reads.
- R10: A data read returns the input latch when control bit 5 (direction) is 1, and the last written data byte when it is 0.
- R11: `in_load` copies `in_data` into the input latch at the edge. A data read in that same cycle returns the value the latch held before the load.
- R12: After reset, both data latches hold 0xFF, status is 0xD9, control is 0xCC, interrupt-pending is 0 and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_data | input | 8 | Byte for the input latch |
| in_load | input | 1 | Load strobe for the input latch |
| tx_data | output | 8 | Transmitted byte |
| tx_valid | output | 1 | One-cycle transmit pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bus carries one access per cycle. The one real collision is an input-latch load arriving in the same cycle as a data read with the direction bit set. The bench forces this directly: it sets direction, pulses `in_load` with a fresh byte during a data read, and requires the old latch value on the bus and the new value on the next read. The random phase then drives `in_load` on about a quarter of all cycles, independently of the bus, and judges every read against a model that samples the latch before applying the load.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;

  // control bit positions
  localparam int CB_STROBE = 0;
  localparam int CB_INIT   = 2;
  localparam int CB_SELECT = 3;
  localparam int CB_IRQEN  = 4;
  localparam int CB_DIR    = 5;

  // status bit positions
  localparam int SB_ACK  = 6;
  localparam int SB_BUSY = 7;

  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [BYTE_W-1:0] RD_EMPTY   = 8'hFF;
endpackage

// File: rtl/pp_data_path.sv
module pp_data_path
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              in_load,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              send,
  output logic [BYTE_W-1:0] dw_q,
  output logic [BYTE_W-1:0] dr_q,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dw_q     <= DATA_RST;
      dr_q     <= DATA_RST;
      tx_data  <= DATA_RST;
      tx_valid <= 1'b0;
    end else begin
      if (wr_data) dw_q <= wdata;
      if (in_load) dr_q <= in_data;
      tx_valid <= send;
      if (send) tx_data <= dw_q;
    end
  end
endmodule

// File: rtl/pp_ctrl_stat.sv
module pp_ctrl_stat
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              pend_q,
  output logic              send
);
  logic [BYTE_W-1:0] ctrl_nx;
  logic              sel_path;
  logic              stat_step;

  assign ctrl_nx   = wdata | CTRL_FORCE;
  assign sel_path  = wr_ctrl & ctrl_nx[CB_INIT] & ctrl_nx[CB_SELECT];
  assign send      = sel_path & ctrl_nx[CB_STROBE] & ~ctrl_q[CB_STROBE];
  assign stat_step = rd_stat & ~stat_q[SB_BUSY] & ~ctrl_q[CB_STROBE];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_nx;
        if (!ctrl_nx[CB_INIT]) begin
          stat_q <= STAT_INIT;
        end else if (sel_path) begin
          if (ctrl_nx[CB_STROBE]) stat_q[SB_BUSY] <= 1'b0;
          else if (ctrl_q[CB_IRQEN]) pend_q <= 1'b1;
        end
      end
      if (rd_stat) pend_q <= 1'b0;
      if (stat_step) begin
        if (stat_q[SB_ACK]) begin
          stat_q[SB_ACK] <= 1'b0;
        end else begin
          stat_q[SB_ACK]  <= 1'b1;
          stat_q[SB_BUSY] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_load,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              irq
);
  localparam int OFS_W = 3;

  logic [OFS_W-1:0]  ofs;
  logic              wr_acc, rd_acc;
  logic [BYTE_W-1:0] dw_w, dr_w, ctrl_w, stat_w;
  logic              pend_w, send_w;
  logic [BYTE_W-1:0] rd_mux;

  assign ofs    = bus_addr[OFS_W-1:0];
  assign wr_acc = bus_sel & bus_we;
  assign rd_acc = bus_sel & ~bus_we;

  pp_data_path u_dp (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_acc && ofs == OFS_DATA),
    .wdata    (bus_wdata),
    .in_load  (in_load),
    .in_data  (in_data),
    .send     (send_w),
    .dw_q     (dw_w),
    .dr_q     (dr_w),
    .tx_data  (tx_data),
    .tx_valid (tx_valid)
  );

  pp_ctrl_stat u_cs (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_acc && ofs == OFS_CTRL),
    .rd_stat (rd_acc && ofs == OFS_STAT),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_w),
    .stat_q  (stat_w),
    .pend_q  (pend_w),
    .send    (send_w)
  );

  always_comb begin
    case (ofs)
      OFS_DATA: rd_mux = ctrl_w[CB_DIR] ? dr_w : dw_w;
      OFS_STAT: rd_mux = stat_w;
      OFS_CTRL: rd_mux = ctrl_w;
      default:  rd_mux = RD_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= RD_EMPTY;
    else if (rd_acc) bus_rdata <= rd_mux;
  end

  assign irq = pend_w;
endmodule

// File: rtl/pp_regs_chk.sv
module pp_regs_chk
  import pp_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              tx_valid,
  input logic              irq,
  input logic [BYTE_W-1:0] stat_w,
  input logic [BYTE_W-1:0] ctrl_w
);
  logic wr_c, rd_s, rd_c, rd_x;
  assign wr_c = bus_sel & bus_we & (bus_addr[2:0] == OFS_CTRL);
  assign rd_s = bus_sel & ~bus_we & (bus_addr[2:0] == OFS_STAT);
  assign rd_c = bus_sel & ~bus_we & (bus_addr[2:0] == OFS_CTRL);
  assign rd_x = bus_sel & ~bus_we & (bus_addr[2:0] > OFS_CTRL);

  AST_UNIMP_READ: assert property (@(posedge clk) disable iff (rst)
    rd_x |=> bus_rdata == RD_EMPTY); // R2
  AST_CTRL_TOP: assert property (@(posedge clk) disable iff (rst)
    rd_c |=> bus_rdata[7:6] == 2'b11); // R3
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_c && !bus_wdata[CB_INIT]) |=> stat_w == STAT_INIT); // R4
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid); // R5
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_c && bus_wdata[CB_INIT] && bus_wdata[CB_SELECT] && !bus_wdata[CB_STROBE]
     && ctrl_w[CB_IRQEN]) |=> irq); // R6
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
    rd_s |=> !irq); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_c || rd_s) |=> $stable(irq)); // R9
endmodule

bind pp_regs pp_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .stat_w    (stat_w),
  .ctrl_w    (ctrl_w)
);

// File: tb/pp_regs_tb.sv
module pp_regs_tb_top;
  localparam real CLK_NS = 8.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] in_data = '0;
  logic       in_load = 1'b0;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_dw, m_dr, m_st, m_ct;
  logic       m_pend;

  always #(CLK_NS/2) clk = ~clk;

  pp_regs dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_data(in_data), .in_load(in_load), .tx_data(tx_data),
    .tx_valid(tx_valid), .irq(irq)
  );

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0:    return m_ct[5] ? m_dr : m_dw;
      3'd1:    return m_st;
      3'd2:    return m_ct;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit s, input bit w, input logic [2:0] a,
                       input logic [7:0] d, input bit ld, input logic [7:0] ldv,
                       input string req);
    logic [7:0] exp_rd, nv, exp_tx;
    bit         exp_txv;
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    in_load = ld; in_data = ldv;
    exp_txv = 0; exp_tx = 8'h00; exp_rd = 8'h00;
    if (s && !w) begin
      exp_rd = model_read(a);
      if (a == 3'd1) begin
        m_pend = 0;
        if (!m_st[7] && !m_ct[0]) begin
          if (m_st[6]) m_st[6] = 1'b0;
          else m_st[7:6] = 2'b11;
        end
      end
    end
    if (s && w) begin
      if (a == 3'd0) m_dw = d;
      if (a == 3'd2) begin
        nv = d | 8'hC0;
        if (!nv[2]) m_st = 8'hD8;
        else if (nv[3]) begin
          if (nv[0]) begin
            m_st[7] = 1'b0;
            if (!m_ct[0]) begin exp_txv = 1; exp_tx = m_dw; end
          end else if (m_ct[4]) m_pend = 1;
        end
        m_ct = nv;
      end
    end
    if (ld) m_dr = ldv;
    @(negedge clk);
    bus_sel = 0; in_load = 0;
    if (s && !w) check(req, "read data", bus_rdata, exp_rd);
    check(req, "tx_valid", {7'd0, tx_valid}, {7'd0, exp_txv});
    if (exp_txv) check(req, "tx_data", tx_data, exp_tx);
    check(req, "irq", {7'd0, irq}, {7'd0, m_pend});
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_pend = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R12: reset values
    check("R12", "tx_valid", {7'd0, tx_valid}, 8'd0);
    cycle(1, 0, 3'd0, 8'h00, 0, 8'h00, "R12");
    cycle(1, 0, 3'd1, 8'h00, 0, 8'h00, "R12");
    cycle(1, 0, 3'd2, 8'h00, 0, 8'h00, "R12");
    // R1 / R10: write and read back data, direction out
    cycle(1, 1, 3'd0, 8'h5A, 0, 8'h00, "R1");
    cycle(1, 0, 3'd0, 8'h00, 0, 8'h00, "R10");
    cycle(0, 0, 3'd0, 8'h00, 0, 8'h00, "R1");   // rdata held
    check("R1", "held read data", bus_rdata, 8'h5A);
    // R4 / R3
    cycle(1, 1, 3'd2, 8'h00, 0, 8'h00, "R4");
    cycle(1, 0, 3'd1, 8'h00, 0, 8'h00, "R4");
    cycle(1, 0, 3'd2, 8'h00, 0, 8'h00, "R3");
    // R5: strobe handshake
    cycle(1, 1, 3'd2, 8'h0C, 0, 8'h00, "R5");
    cycle(1, 1, 3'd2, 8'h0D, 0, 8'h00, "R5");
    cycle(1, 1, 3'd2, 8'h0D, 0, 8'h00, "R5");
    cycle(1, 1, 3'd2, 8'h0C, 0, 8'h00, "R5");
    // R7: polling sequence 58 -> 18 -> D8
    cycle(1, 0, 3'd1, 8'h00, 0, 8'h00, "R7");
    cycle(1, 0, 3'd1, 8'h00, 0, 8'h00, "R7");
    cycle(1, 0, 3'd1, 8'h00, 0, 8'h00, "R7");
    check("R7", "status after advance", bus_rdata, 8'hD8);
    // R6 / R9 / R8
    cycle(1, 1, 3'd2, 8'h1C, 0, 8'h00, "R6");
    cycle(1, 1, 3'd2, 8'h1C, 0, 8'h00, "R6");
    check("R6", "irq raised", {7'd0, irq}, 8'd1);
    cycle(1, 1, 3'd0, 8'hA5, 0, 8'h00, "R9");
    cycle(1, 0, 3'd2, 8'h00, 0, 8'h00, "R9");
    cycle(0, 0, 3'd0, 8'h00, 1, 8'h77, "R9");
    cycle(1, 0, 3'd1, 8'h00, 0, 8'h00, "R8");
    check("R8", "irq cleared", {7'd0, irq}, 8'd0);
    // R11 / R10: reverse direction with same-cycle load
    cycle(1, 1, 3'd2, 8'h2C, 0, 8'h00, "R10");
    cycle(1, 0, 3'd0, 8'h00, 1, 8'h33, "R11");
    cycle(1, 0, 3'd0, 8'h00, 0, 8'h00, "R11");
    check("R11", "loaded byte", bus_rdata, 8'h33);
    // R2: unimplemented offsets and ignored writes
    for (int i = 3; i < 8; i++) cycle(1, 0, 3'(i), 8'h00, 0, 8'h00, "R2");
    cycle(1, 1, 3'd1, 8'h00, 0, 8'h00, "R2");
    cycle(1, 1, 3'd5, 8'h00, 0, 8'h00, "R2");
    cycle(1, 0, 3'd1, 8'h00, 0, 8'h00, "R2");
    cycle(1, 0, 3'd2, 8'h00, 0, 8'h00, "R2");
    cycle(1, 0, 3'd0, 8'h00, 0, 8'h00, "R2");
    // random phase: control values biased toward init/select combos
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if ($urandom % 2 == 0) d[3:2] = 2'b11;
      cycle(($urandom % 4) != 0, ($urandom % 2) == 1, 3'($urandom % 8), d,
            ($urandom % 4) == 0, 8'($urandom), "RND");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule